// File: doc/BRIEF.md
# Recovered Clock Frequency Range Controller

This block keeps a clock-and-data-recovery loop near the rate set by a local reference. It runs on the reference clock and uses a fixed window of `WINDOW` reference cycles. During each window it counts edges of the recovered byte clock. At the end of a measuring window it compares the count with the nominal value for the selected rate and with a tolerance of ±1500 ppm.

If the count is inside the band, the block raises an in-range flag and keeps measuring. If the count is outside the band, or is zero, the block clears the flag and asserts a force command for one full window. The force command pins the recovery loop to the reference-derived rate. The block then releases the loop so it can reacquire the incoming stream, and goes back to measuring.

A rate select input doubles both the nominal count and the tolerance. The link-good output is the block's contribution to a per-channel link fault indicator. It is low while forcing and whenever the in-range flag is low.

Top module: `freq_range_ctrl`

## Requirements
- R1: While rst_ni is low, in_range_o, force_ref_o and link_ok_o are all 0.
- R2: Windows are exactly WINDOW reference cycles long and run back to back from reset release. A measurement result is applied on the last edge of each window.
- R3: When rate_sel_i is 0, a measuring window whose recovered-edge count lies in [WINDOW-T, WINDOW+T] sets in_range_o to 1. T is WINDOW*1500/1000000 (24 at the default of 16000). A count outside that range sets in_range_o to 0.
- R4: An out-of-range result asserts force_ref_o for exactly the next full window. force_ref_o then drops and measuring resumes.
- R5: link_ok_o is 1 only when in_range_o is 1 and force_ref_o is 0.
- R6: in_range_o and force_ref_o change only on the edge that ends a window.
- R7: A window in which the recovered clock does not toggle counts zero and is treated as out of range.
- R8: When rate_sel_i is 1, the nominal count is 2*WINDOW and the tolerance is 2*T.
- R9: After a forced window, in_range_o and link_ok_o return to 1 at the end of the first measuring window that is in range. This is at most one window after the release.
- R10: The result of a forced window is discarded. in_range_o stays 0 through the force window regardless of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; all control logic runs here |
| rst_ni | input | 1 | Active-low asynchronous reset for both clock domains |
| rec_clk_i | input | 1 | Recovered byte clock being measured |
| rate_sel_i | input | 1 | 0: nominal count WINDOW; 1: nominal count 2*WINDOW |
| in_range_o | output | 1 | Result of the last measuring window (1 = within band) |
| force_ref_o | output | 1 | Force recovery loop to reference-derived rate |
| link_ok_o | output | 1 | Link-good contribution; low means fault |

## Verification
The assertions assume that rate_sel_i is held steady through each window. They also assume the recovered clock is slow enough that the Gray-coded count moves by at most a few codes between two reference edges. The stimulus changes rate and rate select only on the falling reference edge right after a window ends. It uses recovered periods at least half the reference period, and keeps each test rate at least two counts away from a band edge. Because of this, the few cycles of synchronizer lag carried into the next window cannot flip a decision.

// File: rtl/freq_rc_pkg.sv
package freq_rc_pkg;
  typedef enum logic {
    ST_MEAS  = 1'b0,
    ST_FORCE = 1'b1
  } rc_state_e;

  localparam int unsigned PPM_LIMIT = 1500;
endpackage

// File: rtl/freq_rc_cdc_count.sv
// Free-running recovered-clock edge counter, carried to the reference domain in Gray code.
module freq_rc_cdc_count #(
  parameter int unsigned CW = 17
) (
  input  logic          rec_clk_i,
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] count_o
);
  logic [CW-1:0] bin_q, gray_q, sync1_q, sync2_q;

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_q + 1'b1;
      gray_q <= bin_q ^ (bin_q >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= gray_q;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    count_o[CW-1] = sync2_q[CW-1];
    for (int i = CW - 2; i >= 0; i--) begin
      count_o[i] = count_o[i+1] ^ sync2_q[i];
    end
  end
endmodule

// File: rtl/freq_rc_window.sv
module freq_rc_window #(
  parameter int unsigned WINDOW = 16000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam int unsigned WW = $clog2(WINDOW);

  logic [WW-1:0] cnt_q;

  assign win_end_o = (cnt_q == WW'(WINDOW - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/freq_range_ctrl.sv
module freq_range_ctrl
  import freq_rc_pkg::*;
#(
  parameter int unsigned WINDOW = 16000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rec_clk_i,
  input  logic rate_sel_i,
  output logic in_range_o,
  output logic force_ref_o,
  output logic link_ok_o
);
  localparam int unsigned CNT_W = $clog2(4 * WINDOW) + 1;
  localparam int unsigned TOL   = (WINDOW * PPM_LIMIT) / 1000000;
  localparam logic [CNT_W-1:0] LO_BASE = CNT_W'(WINDOW - TOL);
  localparam logic [CNT_W-1:0] HI_BASE = CNT_W'(WINDOW + TOL);
  localparam logic [CNT_W-1:0] LO_DBL  = CNT_W'(2 * (WINDOW - TOL));
  localparam logic [CNT_W-1:0] HI_DBL  = CNT_W'(2 * (WINDOW + TOL));

  logic             win_end;
  logic [CNT_W-1:0] cur_cnt, snap_q, delta;
  logic [CNT_W-1:0] lo_lim, hi_lim;
  logic             cnt_ok;
  rc_state_e        state_q;
  logic             in_range_q;

  freq_rc_window #(.WINDOW(WINDOW)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_o (win_end)
  );

  freq_rc_cdc_count #(.CW(CNT_W)) u_cnt (
    .rec_clk_i (rec_clk_i),
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .count_o   (cur_cnt)
  );

  assign delta  = cur_cnt - snap_q;
  assign lo_lim = rate_sel_i ? LO_DBL : LO_BASE;
  assign hi_lim = rate_sel_i ? HI_DBL : HI_BASE;
  // zero count means no recovered clock: always a fail
  assign cnt_ok = (delta != '0) && (delta >= lo_lim) && (delta <= hi_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q     <= '0;
      state_q    <= ST_MEAS;
      in_range_q <= 1'b0;
    end else if (win_end) begin
      snap_q <= cur_cnt;
      unique case (state_q)
        ST_MEAS: begin
          in_range_q <= cnt_ok;
          state_q    <= cnt_ok ? ST_MEAS : ST_FORCE;
        end
        ST_FORCE: state_q <= ST_MEAS;  // release, measure again
        default:  state_q <= ST_MEAS;
      endcase
    end
  end

  assign in_range_o  = in_range_q;
  assign force_ref_o = (state_q == ST_FORCE);
  assign link_ok_o   = in_range_q && (state_q != ST_FORCE);
endmodule

// File: rtl/freq_rc_chk.sv
module freq_rc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic win_end_i,
  input logic in_range_o,
  input logic force_ref_o,
  input logic link_ok_o
);
  AST_FAULT_WHILE_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ref_o |-> !link_ok_o); // R5

  AST_NO_RANGE_WHILE_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ref_o |-> !in_range_o); // R10

  AST_RANGE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(in_range_o)); // R6

  AST_FORCE_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(force_ref_o)); // R6

  AST_FORCE_ONE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_ref_o && win_end_i) |=> !force_ref_o); // R4

  AST_FAIL_THEN_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_ref_o && win_end_i) |=> (in_range_o != force_ref_o)); // R4

  always_comb begin
    if (rst_ni === 1'b0) begin
      AST_RESET_QUIET: assert (!force_ref_o && !in_range_o && !link_ok_o); // R1
    end
  end
endmodule

bind freq_range_ctrl freq_rc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_end_i   (win_end),
  .in_range_o  (in_range_o),
  .force_ref_o (force_ref_o),
  .link_ok_o   (link_ok_o)
);

// File: tb/sim_freq_range_ctrl.sv
`timescale 1ps/1ps
module sim_freq_range_ctrl;
  localparam int W       = 4000;
  localparam int REF_PS  = 4000;
  localparam int TOL     = (W * 1500) / 1000000;

  logic clk = 1'b0, rst_ni = 1'b0, rec_clk = 1'b0, rate_sel = 1'b0;
  logic in_range, force_ref, link_ok;
  logic rec_en = 1'b1;
  int   rec_half = 2000;
  int   errors = 0, checks = 0;
  int   edges = 0;
  bit   done = 1'b0;
  // reference model state
  bit   m_force = 1'b0, m_in = 1'b0;

  always #(REF_PS / 2) clk = ~clk;

  always begin
    if (rec_en) #(rec_half) rec_clk = ~rec_clk;
    else #(1000);
  end

  freq_range_ctrl #(.WINDOW(W)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rec_clk_i   (rec_clk),
    .rate_sel_i  (rate_sel),
    .in_range_o  (in_range),
    .force_ref_o (force_ref),
    .link_ok_o   (link_ok)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at ref edge %0d: actual=%b expected=%b", req, edges, act, exp);
    end
  endtask

  // one window: set rate at its start, compare every cycle
  task automatic run_win(input int half, input bit en, input bit rs, input string tag);
    real n, nom, tol;
    bit  ok;
    rec_half = half;
    rec_en   = en;
    rate_sel = rs;
    n   = en ? (real'(W) * REF_PS) / (2.0 * half) : 0.0;
    nom = rs ? 2.0 * W : 1.0 * W;
    tol = rs ? 2.0 * TOL : 1.0 * TOL;
    ok  = (n > 0.0) && (n >= nom - tol) && (n <= nom + tol);
    for (int c = 0; c < W; c++) begin
      @(posedge clk);
      edges++;
      if (edges % W == 0) begin
        if (!m_force) begin
          m_in    = ok;
          m_force = !ok;
        end else begin
          m_force = 1'b0;
        end
      end
      @(negedge clk);
      chk(in_range, m_in, {tag, " in_range R2 R6"});
      chk(force_ref, m_force, {tag, " force R4"});
      chk(link_ok, m_in && !m_force, {tag, " link_ok R5"});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_range, 1'b0, "R1 in_range");
    chk(force_ref, 1'b0, "R1 force");
    chk(link_ok, 1'b0, "R1 link_ok");
    rst_ni = 1'b1;
    run_win(2000, 1, 0, "R3 exact");
    run_win(2002, 1, 0, "R3 slow 0.1pct");
    run_win(2020, 1, 0, "R3 slow 1pct");
    run_win(2020, 1, 0, "R4 forced");
    run_win(2000, 1, 0, "R9 relock");
    run_win(1980, 1, 0, "R3 fast 1pct");
    run_win(2000, 1, 0, "R10 forced good");
    run_win(2000, 1, 0, "R9 relock");
    run_win(2000, 0, 0, "R7 no clock");
    run_win(2000, 1, 0, "R4 forced");
    run_win(1000, 1, 1, "R8 double ok");
    run_win(2000, 1, 1, "R8 base at double");
    run_win(2000, 1, 1, "R4 forced");
    run_win(2000, 1, 0, "R9 relock base");
    run_win(2006, 1, 0, "R3 slow 0.3pct");
    run_win(2000, 1, 0, "R4 forced");
    run_win(2000, 1, 0, "R9 relock");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule